// File: doc/BRIEF.md
# SIMD Instruction Fault Qualifier

This block sits in front of a packed 16-bit multiply unit and decides, before the operation is allowed to execute, whether it must be turned into an exception. Decode logic presents the relevant machine state for one instruction: control bits, a feature flag, a lock-prefix flag, the operand width, a memory-operand flag with the low bits of its effective address, and the results of segment and canonical-address checks. It also presents a pending x87 error flag, the privilege level and the alignment-check enable. The strobe `check_vld_i` marks the cycle in which these inputs are meaningful.

One clock edge later the block returns a one-hot fault vector with at most one bit set, chosen by fixed priority, together with an execute-permission bit that is high only when no fault was found. Page faults and delivery of the exception to the core are handled elsewhere.

Top module: `simd_fault_qual`

## Requirements
- R1: While reset is active and in the first cycle after it, `done_o`, `allow_o` and every bit of `fault_o` are 0.
- R2: `done_o` is 1 exactly in the cycle after a cycle with `check_vld_i` high. In any cycle that does not follow a strobe, `fault_o` is all zero and `allow_o` is 0.
- R3: The emulation control bit (`emul_i`) or the lock prefix (`lock_i`) raises the invalid-opcode fault, which is `fault_o` bit 0. This applies to either operand width.
- R4: In the 128-bit form (`wide_i`=1), a clear extended-state enable (`ext_state_en_i`) or a clear wide-SIMD feature flag (`wide_feat_i`) raises the invalid-opcode fault. In the 64-bit form these two inputs have no effect.
- R5: The task-switched control bit (`task_sw_i`) raises the device-not-available fault, which is `fault_o` bit 1.
- R6: A pending x87 error (`x87_pend_i`) raises the math fault, `fault_o` bit 2, only in the 64-bit form. In the 128-bit form it has no effect.
- R7: A 128-bit form with a memory operand whose address has any of bits [3:0] set raises the general-protection fault, `fault_o` bit 3, whatever the segment. A register operand (`mem_i`=0) never triggers this fault.
- R8: With a memory operand, a stack-segment limit or canonical violation (`stk_viol_i`) raises the stack fault, `fault_o` bit 4. Any other segment-limit or canonical violation (`seg_viol_i`) raises the general-protection fault. Both inputs are ignored when `mem_i`=0.
- R9: The alignment-check fault, `fault_o` bit 5, is raised only when all of these hold: the form is 64-bit, there is a memory operand, `ac_en_i`=1, `cpl_i`=3, and address bits [2:0] are not all zero.
- R10: When several conditions hold, only the lowest-numbered fault bit is reported. The priority order is invalid-opcode, device-not-available, math, general-protection, stack, alignment.
- R11: `allow_o` is 1 exactly when `done_o` is 1 and `fault_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_vld_i | input | 1 | Inputs are valid for one qualification this cycle |
| emul_i | input | 1 | Emulation control bit |
| task_sw_i | input | 1 | Task-switched control bit |
| ext_state_en_i | input | 1 | OS extended-state save enable |
| wide_feat_i | input | 1 | Processor supports the 128-bit integer SIMD forms |
| lock_i | input | 1 | Lock prefix present |
| wide_i | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| mem_i | input | 1 | Source operand is in memory |
| addr_lo_i | input | ADDR_LSB_W (4) | Low bits of the effective address |
| seg_viol_i | input | 1 | Non-stack segment-limit or canonical violation |
| stk_viol_i | input | 1 | Stack-segment limit or canonical violation |
| x87_pend_i | input | 1 | Unmasked x87 error is pending |
| cpl_i | input | 2 | Current privilege level |
| ac_en_i | input | 1 | Alignment checking enabled |
| done_o | output | 1 | Qualification result is valid |
| fault_o | output | 6 | One-hot fault: bit0 UD, bit1 NM, bit2 MF, bit3 GP, bit4 SS, bit5 AC |
| allow_o | output | 1 | Instruction may execute |

## Verification
Every result of this block is due exactly one clock edge after the cycle in which `check_vld_i` is high. The bench drives the inputs and the strobe on a falling edge and drops the strobe on the next falling edge. It reads `done_o`, `fault_o` and `allow_o` at that same falling edge, which is half a period after the single register stage has loaded. A further falling-edge sample with no strobe confirms that the outputs return to their idle value, and the expected vector always comes from a bench model of the priority rules.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
   localparam int unsigned NUM_FAULTS = 6;

   // bit position of each fault class in the one-hot vector; lower index wins
   typedef enum int unsigned {
      F_UD = 0,
      F_NM = 1,
      F_MF = 2,
      F_GP = 3,
      F_SS = 4,
      F_AC = 5
   } fault_idx_e;

   typedef logic [NUM_FAULTS-1:0] fault_vec_t;
endpackage

// File: rtl/sfq_cond.sv
module sfq_cond
   import sfq_pkg::*;
#(
   parameter int unsigned WIDE_ALIGN_LG2   = 4,
   parameter int unsigned NARROW_ALIGN_LG2 = 3,
   parameter int unsigned ADDR_LSB_W       = 4,
   parameter logic [1:0]  AC_RING          = 2'd3
) (
   input  logic                  emul_i,
   input  logic                  task_sw_i,
   input  logic                  ext_state_en_i,
   input  logic                  wide_feat_i,
   input  logic                  lock_i,
   input  logic                  wide_i,
   input  logic                  mem_i,
   input  logic [ADDR_LSB_W-1:0] addr_lo_i,
   input  logic                  seg_viol_i,
   input  logic                  stk_viol_i,
   input  logic                  x87_pend_i,
   input  logic [1:0]            cpl_i,
   input  logic                  ac_en_i,
   output fault_vec_t            raw_o
);
   logic wide_mis;
   logic narrow_mis;

   // misalignment detectors; a zero-width check means "never misaligned"
   generate
      if (WIDE_ALIGN_LG2 == 0) begin : g_wide_none
         assign wide_mis = 1'b0;
      end else begin : g_wide_chk
         assign wide_mis = |addr_lo_i[WIDE_ALIGN_LG2-1:0];
      end
      if (NARROW_ALIGN_LG2 == 0) begin : g_nar_none
         assign narrow_mis = 1'b0;
      end else begin : g_nar_chk
         assign narrow_mis = |addr_lo_i[NARROW_ALIGN_LG2-1:0];
      end
   endgenerate

   always_comb begin
      raw_o       = '0;
      raw_o[F_UD] = emul_i | lock_i | (wide_i & (~ext_state_en_i | ~wide_feat_i));
      raw_o[F_NM] = task_sw_i;
      raw_o[F_MF] = ~wide_i & x87_pend_i;
      raw_o[F_GP] = mem_i & (seg_viol_i | (wide_i & wide_mis));
      raw_o[F_SS] = mem_i & stk_viol_i;
      raw_o[F_AC] = mem_i & ~wide_i & ac_en_i & (cpl_i == AC_RING) & narrow_mis;
   end
endmodule

// File: rtl/sfq_pick.sv
module sfq_pick #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("sfq_pick: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (i == 0) begin : g_first
            assign grant_o[0] = req_i[0];
         end else begin : g_rest
            assign grant_o[i] = req_i[i] & ~|req_i[i-1:0];
         end
      end
   endgenerate

   // R10: the picker never hands out more than one grant, and grants only a request
   always_comb begin
      p_pick_onehot_r10 : assert ($onehot0(grant_o));
      p_pick_subset_r10 : assert ((grant_o & ~req_i) == '0);
   end
endmodule

// File: rtl/simd_fault_qual.sv
module simd_fault_qual
   import sfq_pkg::*;
#(
   parameter int unsigned WIDE_ALIGN_LG2   = 4,
   parameter int unsigned NARROW_ALIGN_LG2 = 3,
   parameter int unsigned ADDR_LSB_W       = (WIDE_ALIGN_LG2 > NARROW_ALIGN_LG2) ?
                                             WIDE_ALIGN_LG2 : NARROW_ALIGN_LG2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  check_vld_i,
   input  logic                  emul_i,
   input  logic                  task_sw_i,
   input  logic                  ext_state_en_i,
   input  logic                  wide_feat_i,
   input  logic                  lock_i,
   input  logic                  wide_i,
   input  logic                  mem_i,
   input  logic [ADDR_LSB_W-1:0] addr_lo_i,
   input  logic                  seg_viol_i,
   input  logic                  stk_viol_i,
   input  logic                  x87_pend_i,
   input  logic [1:0]            cpl_i,
   input  logic                  ac_en_i,
   output logic                  done_o,
   output logic [NUM_FAULTS-1:0] fault_o,
   output logic                  allow_o
);
   localparam int unsigned MAX_LG2 = (WIDE_ALIGN_LG2 > NARROW_ALIGN_LG2) ?
                                     WIDE_ALIGN_LG2 : NARROW_ALIGN_LG2;

   generate
      if (ADDR_LSB_W != MAX_LG2) begin : g_bad_addr
         $error("simd_fault_qual: ADDR_LSB_W must equal the larger alignment exponent");
      end
      if (MAX_LG2 == 0) begin : g_bad_align
         $error("simd_fault_qual: at least one alignment check must be enabled");
      end
   endgenerate

   fault_vec_t raw;
   fault_vec_t pick;

   sfq_cond #(
      .WIDE_ALIGN_LG2  (WIDE_ALIGN_LG2),
      .NARROW_ALIGN_LG2(NARROW_ALIGN_LG2),
      .ADDR_LSB_W      (ADDR_LSB_W),
      .AC_RING         (2'd3)
   ) u_cond (
      .emul_i        (emul_i),
      .task_sw_i     (task_sw_i),
      .ext_state_en_i(ext_state_en_i),
      .wide_feat_i   (wide_feat_i),
      .lock_i        (lock_i),
      .wide_i        (wide_i),
      .mem_i         (mem_i),
      .addr_lo_i     (addr_lo_i),
      .seg_viol_i    (seg_viol_i),
      .stk_viol_i    (stk_viol_i),
      .x87_pend_i    (x87_pend_i),
      .cpl_i         (cpl_i),
      .ac_en_i       (ac_en_i),
      .raw_o         (raw)
   );

   sfq_pick #(.N(NUM_FAULTS)) u_pick (
      .req_i  (raw),
      .grant_o(pick)
   );

   logic       done_q;
   fault_vec_t fault_q;
   logic       allow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         fault_q <= '0;
         allow_q <= 1'b0;
      end else begin
         done_q  <= check_vld_i;
         fault_q <= check_vld_i ? pick : '0;
         allow_q <= check_vld_i & ~|pick;
      end
   end

   assign done_o  = done_q;
   assign fault_o = fault_q;
   assign allow_o = allow_q;

   p_onehot_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault_o));

   p_allow_clean_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      allow_o |-> (done_o && fault_o == '0));

   p_idle_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (fault_o == '0 && !allow_o));

   p_emul_wins_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) && $past(emul_i) |-> fault_o[F_UD]);

   p_mf_narrow_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) && fault_o[F_MF] |-> !$past(wide_i));

   p_ac_ring_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) && fault_o[F_AC] |-> ($past(cpl_i) == 2'd3 && $past(ac_en_i)));
endmodule

// File: tb/sim_simd_fault_qual.sv
module sim_simd_fault_qual;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic check_vld_i = 1'b0;
   logic emul_i = 0, task_sw_i = 0, ext_state_en_i = 1, wide_feat_i = 1, lock_i = 0;
   logic wide_i = 0, mem_i = 0, seg_viol_i = 0, stk_viol_i = 0, x87_pend_i = 0, ac_en_i = 0;
   logic [3:0] addr_lo_i = '0;
   logic [1:0] cpl_i = '0;
   logic       done_o, allow_o;
   logic [5:0] fault_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   simd_fault_qual u0 (
      .clk(clk), .rst_n(rst_n), .check_vld_i(check_vld_i),
      .emul_i(emul_i), .task_sw_i(task_sw_i), .ext_state_en_i(ext_state_en_i),
      .wide_feat_i(wide_feat_i), .lock_i(lock_i), .wide_i(wide_i), .mem_i(mem_i),
      .addr_lo_i(addr_lo_i), .seg_viol_i(seg_viol_i), .stk_viol_i(stk_viol_i),
      .x87_pend_i(x87_pend_i), .cpl_i(cpl_i), .ac_en_i(ac_en_i),
      .done_o(done_o), .fault_o(fault_o), .allow_o(allow_o)
   );

   function automatic logic [5:0] model();
      logic [5:0] r;
      r[0] = emul_i | lock_i | (wide_i & (!ext_state_en_i | !wide_feat_i));
      r[1] = task_sw_i;
      r[2] = !wide_i & x87_pend_i;
      r[3] = mem_i & (seg_viol_i | (wide_i & (addr_lo_i[3:0] != 0)));
      r[4] = mem_i & stk_viol_i;
      r[5] = mem_i & !wide_i & ac_en_i & (cpl_i == 2'd3) & (addr_lo_i[2:0] != 0);
      for (int i = 0; i < 6; i++)
         if (r[i]) return 6'b1 << i;
      return 6'b0;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_in();
      emul_i = 0; task_sw_i = 0; ext_state_en_i = 1; wide_feat_i = 1; lock_i = 0;
      wide_i = 0; mem_i = 0; seg_viol_i = 0; stk_viol_i = 0; x87_pend_i = 0;
      ac_en_i = 0; addr_lo_i = '0; cpl_i = '0;
   endtask

   // strobe on a falling edge, sample one full period later (one register stage)
   task automatic run(input string req, input logic [5:0] exp);
      @(negedge clk);
      check_vld_i = 1'b1;
      @(negedge clk);
      check_vld_i = 1'b0;
      check(req, {done_o, allow_o, fault_o}, {1'b1, (exp == 6'b0), exp});
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [5:0] e;
      void'($urandom(32'h5eed_0a17));
      repeat (3) @(negedge clk);
      check("R1 in reset", {done_o, allow_o, fault_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {done_o, allow_o, fault_o}, 8'h00);

      // R11 / R2: clean 64-bit register form
      clear_in(); run("R11 clean narrow", 6'b000000);
      @(negedge clk);
      check("R2 no strobe idle", {done_o, allow_o, fault_o}, 8'h00);
      clear_in(); wide_i = 1; run("R11 clean wide", 6'b000000);

      // R3
      clear_in(); emul_i = 1; run("R3 emul", 6'b000001);
      clear_in(); lock_i = 1; wide_i = 1; run("R3 lock", 6'b000001);
      // R4
      clear_in(); wide_i = 1; ext_state_en_i = 0; run("R4 ext clear wide", 6'b000001);
      clear_in(); wide_i = 1; wide_feat_i = 0; run("R4 feat clear wide", 6'b000001);
      clear_in(); ext_state_en_i = 0; wide_feat_i = 0; run("R4 narrow ignores", 6'b000000);
      // R5
      clear_in(); task_sw_i = 1; run("R5 task switched", 6'b000010);
      // R6
      clear_in(); x87_pend_i = 1; run("R6 narrow pending", 6'b000100);
      clear_in(); x87_pend_i = 1; wide_i = 1; run("R6 wide ignores", 6'b000000);
      // R7
      clear_in(); wide_i = 1; mem_i = 1; addr_lo_i = 4'h8; run("R7 wide misaligned", 6'b001000);
      clear_in(); wide_i = 1; mem_i = 1; addr_lo_i = 4'h0; run("R7 wide aligned", 6'b000000);
      clear_in(); wide_i = 1; addr_lo_i = 4'h8; run("R7 register form", 6'b000000);
      clear_in(); mem_i = 1; addr_lo_i = 4'h8; run("R7 narrow 8-aligned", 6'b000000);
      // R8
      clear_in(); mem_i = 1; seg_viol_i = 1; run("R8 data seg", 6'b001000);
      clear_in(); mem_i = 1; stk_viol_i = 1; run("R8 stack seg", 6'b010000);
      clear_in(); stk_viol_i = 1; seg_viol_i = 1; run("R8 register ignores", 6'b000000);
      // R9
      clear_in(); mem_i = 1; ac_en_i = 1; cpl_i = 3; addr_lo_i = 4'h4; run("R9 ac fires", 6'b100000);
      clear_in(); mem_i = 1; ac_en_i = 1; cpl_i = 0; addr_lo_i = 4'h4; run("R9 ring0", 6'b000000);
      clear_in(); mem_i = 1; ac_en_i = 0; cpl_i = 3; addr_lo_i = 4'h1; run("R9 disabled", 6'b000000);
      clear_in(); wide_i = 1; mem_i = 1; ac_en_i = 1; cpl_i = 3; addr_lo_i = 4'h2;
      run("R9 wide gives GP", 6'b001000);
      // R10
      clear_in(); emul_i = 1; task_sw_i = 1; mem_i = 1; stk_viol_i = 1; run("R10 UD first", 6'b000001);
      clear_in(); task_sw_i = 1; x87_pend_i = 1; mem_i = 1; ac_en_i = 1; cpl_i = 3; addr_lo_i = 4'h3;
      run("R10 NM first", 6'b000010);
      clear_in(); mem_i = 1; seg_viol_i = 1; stk_viol_i = 1; run("R10 GP before SS", 6'b001000);
      clear_in(); mem_i = 1; stk_viol_i = 1; ac_en_i = 1; cpl_i = 3; addr_lo_i = 4'h1;
      run("R10 SS before AC", 6'b010000);

      // constrained random mix, R3..R11
      for (int n = 0; n < 400; n++) begin
         emul_i = ($urandom_range(0, 9) == 0);
         task_sw_i = ($urandom_range(0, 7) == 0);
         ext_state_en_i = ($urandom_range(0, 7) != 0);
         wide_feat_i = ($urandom_range(0, 7) != 0);
         lock_i = ($urandom_range(0, 9) == 0);
         wide_i = $urandom_range(0, 1);
         mem_i = $urandom_range(0, 1);
         seg_viol_i = ($urandom_range(0, 7) == 0);
         stk_viol_i = ($urandom_range(0, 7) == 0);
         x87_pend_i = ($urandom_range(0, 5) == 0);
         ac_en_i = $urandom_range(0, 1);
         cpl_i = 2'($urandom_range(0, 3));
         addr_lo_i = ($urandom_range(0, 1) == 0) ? 4'h0 : 4'($urandom_range(0, 15));
         e = model();
         run("R10 random", e);
      end

      @(negedge clk);
      check("R2 final idle", {done_o, allow_o, fault_o}, 8'h00);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule